// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block gathers a parameterised set of external interrupt inputs and routes them to several hart contexts through a memory-mapped register file. Every source has a small priority value. Every context has its own enable mask, its own priority threshold and a claim/complete register. A context's request line goes high while at least one source that is pending, enabled for it and ranked strictly above its threshold is waiting.

Software takes an interrupt in two steps. It reads the context's claim register, which returns the winning source ID and clears that source's pending bit in the same access. When service is finished, it writes the same ID back to the same register. Between those two steps the source cannot be presented again. A per-source parameter bit sets whether an input is captured as a level-high or a rising-edge trigger. The register port is a single-cycle request interface. Writes take effect at the clock edge that samples the request, and read data is registered, so it is valid in the cycle after the request.

Top module: `pic_core`

## Requirements
- R1: After reset all priorities, enable bits and thresholds are zero, no context request line is high, and a claim read returns 0.
- R2: The priority of source N is the 32-bit word at byte offset 4*N. Only the low 3 bits are stored and the upper bits read as zero. Source ID 0 always reads 0 and ignores writes.
- R3: The enable mask of context C starts at 0x2000 + 0x80*C. Source N is bit N%32 of the word at offset (N/32)*4 in that window. Bit 0 of word 0 (ID 0) reads as zero, and each context's mask is independent.
- R4: The threshold of context C is at 0x200000 + 0x1000*C (3 bits, upper bits read zero). A source can raise a context only when its priority is strictly greater than the threshold, so priority 0 masks a source and threshold 7 blocks all sources.
- R5: A read of 0x200000 + 0x1000*C + 4 returns the ID of the highest-priority eligible source for context C, or 0 if there is none, and clears that source's pending bit.
- R6: A claimed source is not presented to any context again until a completion write of its ID arrives.
- R7: Among eligible sources of equal priority, the lowest source ID wins the claim.
- R8: A completion write that names a source not enabled in the written context is ignored, and the source stays in service.
- R9: A level-captured source whose input is still high at completion becomes pending again. A source whose input has gone low does not.
- R10: An edge-captured source (parameter bit set; by default IDs 8 to 15) becomes pending only on a rising input. A rising edge that arrives while the source is pending or claimed, including in the same cycle as its claim, is remembered and presented after completion. A level held high does not re-trigger.
- R11: Each context's request line and claim result depend only on that context's own enables and threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req_i | input | 1 | Register access request, one cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_src_i | input | NUM_SRC | Interrupt inputs indexed by source ID (bit 0 unused) |
| ctx_irq_o | output | NUM_CTX | Interrupt request per context |

## Verification
The case that needs the most care is a claim read on an edge-captured source that lands in the same clock cycle as a fresh rising edge on that input. The claim must take the source out of the pending state, and the new edge must not be lost. The bench provokes this by driving the claim request and the input rise in the same cycle. It then checks three things: the claim returns the source, the request line stays low while the source is in service, and the request line returns after completion with a second claim returning the same ID. A second case has a level source still high when its completion is written, and the bench checks that the source is re-armed without any new input activity.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam logic [31:0] PRIO_WIN_END = 32'h0000_1000;
    localparam logic [31:0] EN_WIN_BASE  = 32'h0000_2000;
    localparam int unsigned EN_STRIDE_SH = 7;    // 0x80 bytes per context
    localparam logic [31:0] CTL_WIN_BASE = 32'h0020_0000;
    localparam int unsigned CTL_STRIDE_SH = 12;  // 0x1000 bytes per context
    localparam logic [11:0] CTL_OFS_THR  = 12'h000;
    localparam logic [11:0] CTL_OFS_CLM  = 12'h004;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_PRIO,
        RK_ENABLE,
        RK_THRESH,
        RK_CLAIM
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [9:0]  idx;   // source ID or enable word index
        logic [13:0] ctx;   // context index
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [31:0] a,
                                             input int unsigned nsrc,
                                             input int unsigned nctx);
        reg_sel_t    s;
        logic [31:0] ofs;
        logic [31:0] c;
        s = '{kind: RK_NONE, idx: '0, ctx: '0};
        if (a[1:0] == 2'b00) begin
            if (a < PRIO_WIN_END) begin
                if (32'(a[11:2]) < nsrc) begin
                    s.kind = RK_PRIO;
                    s.idx  = a[11:2];
                end
            end else if (a >= EN_WIN_BASE && a < CTL_WIN_BASE) begin
                ofs = a - EN_WIN_BASE;
                c   = ofs >> EN_STRIDE_SH;
                if (c < nctx && 32'(ofs[6:2]) < (nsrc + 31) / 32) begin
                    s.kind = RK_ENABLE;
                    s.idx  = {5'b0, ofs[6:2]};
                    s.ctx  = c[13:0];
                end
            end else if (a >= CTL_WIN_BASE) begin
                ofs = a - CTL_WIN_BASE;
                c   = ofs >> CTL_STRIDE_SH;
                if (c < nctx) begin
                    s.ctx = c[13:0];
                    if (ofs[11:0] == CTL_OFS_THR)      s.kind = RK_THRESH;
                    else if (ofs[11:0] == CTL_OFS_CLM) s.kind = RK_CLAIM;
                end
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_gateway.sv
module irq_gateway #(
    parameter bit EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic src_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pending_o
);

    logic pend_q;
    logic busy_q;
    logic idle;
    logic trig;

    assign idle      = !pend_q && !busy_q;
    assign pending_o = pend_q;

    generate
        if (EDGE) begin : g_edge
            logic prev_q;
            logic held_q;
            logic rise;

            assign rise = src_i && !prev_q;
            assign trig = rise || held_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= 1'b0;
                    held_q <= 1'b0;
                end else begin
                    prev_q <= src_i;
                    if (idle && trig)
                        held_q <= 1'b0;
                    else if (rise)
                        held_q <= 1'b1;
                end
            end

            AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (rst)
                (rise && (pend_q || busy_q)) |=> held_q); // R10
        end else begin : g_level
            assign trig = src_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            if (claim_i) begin
                pend_q <= 1'b0;
                busy_q <= 1'b1;
            end else if (idle && trig) begin
                pend_q <= 1'b1;
            end
            if (complete_i)
                busy_q <= 1'b0;
        end
    end

    AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (rst)
        claim_i |=> (!pend_q && busy_q)); // R5

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !complete_i) |=> !pend_q); // R6

endmodule

// File: rtl/irq_ctx_arbiter.sv
module irq_ctx_arbiter #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 3,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_SRC-1:0]          pend_i,
    input  logic [NUM_SRC-1:0]          en_i,
    input  logic [NUM_SRC*PRIO_W-1:0]   prio_i,
    input  logic [PRIO_W-1:0]           thr_i,
    output logic [ID_W-1:0]             win_id_o,
    output logic                        irq_o
);

    logic [PRIO_W-1:0] best_p;
    logic              found;

    always_comb begin
        best_p   = '0;
        found    = 1'b0;
        win_id_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_i[i] && en_i[i] &&
                prio_i[i*PRIO_W +: PRIO_W] > thr_i &&
                (!found || prio_i[i*PRIO_W +: PRIO_W] > best_p)) begin
                found    = 1'b1;
                best_p   = prio_i[i*PRIO_W +: PRIO_W];
                win_id_o = ID_W'(i);
            end
        end
    end

    assign irq_o = found;

    AST_THR_MAX_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (thr_i == '1) |-> !irq_o); // R4

    AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pend_i[win_id_o] && en_i[win_id_o])); // R5

endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
#(
    parameter int                 NUM_SRC   = 16,
    parameter int                 NUM_CTX   = 2,
    parameter int                 PRIO_W    = 3,
    parameter int                 ADDR_W    = 26,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = 16'hFF00
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_req_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    input  logic [NUM_SRC-1:0] irq_src_i,
    output logic [NUM_CTX-1:0] ctx_irq_o
);

    localparam int ID_W  = $clog2(NUM_SRC);
    localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

    reg_sel_t                  sel;
    logic [PRIO_W-1:0]         prio_q [NUM_SRC];
    logic [NUM_SRC-1:0]        en_q   [NUM_CTX];
    logic [PRIO_W-1:0]         thr_q  [NUM_CTX];
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [NUM_SRC-1:0]        pend_vec;
    logic [NUM_SRC-1:0]        claim_vec;
    logic [NUM_SRC-1:0]        done_vec;
    logic [ID_W-1:0]           win_id [NUM_CTX];
    logic [ID_W-1:0]           cur_win;
    logic [CTX_W-1:0]          cur_ctx;
    logic [ID_W-1:0]           cur_id;
    logic                      claim_rd;
    logic                      done_wr;
    logic [31:0]               rd_mux;
    logic                      unused_bits;

    assign sel     = decode_addr({{(32-ADDR_W){1'b0}}, bus_addr_i}, NUM_SRC, NUM_CTX);
    assign cur_ctx = sel.ctx[CTX_W-1:0];
    assign cur_id  = sel.idx[ID_W-1:0];
    assign cur_win = win_id[cur_ctx];

    assign claim_rd = bus_req_i && !bus_we_i && sel.kind == RK_CLAIM;
    assign done_wr  = bus_req_i &&  bus_we_i && sel.kind == RK_CLAIM;

    assign unused_bits = ^{sel.idx, sel.ctx, irq_src_i[0]};

    // Per-source capture
    assign pend_vec[0]  = 1'b0;
    assign claim_vec[0] = 1'b0;
    assign done_vec[0]  = 1'b0;
    assign prio_flat[PRIO_W-1:0] = '0;

    generate
        for (genvar s = 1; s < NUM_SRC; s++) begin : g_src
            assign claim_vec[s] = claim_rd && cur_win == ID_W'(s);
            assign done_vec[s]  = done_wr && bus_wdata_i == 32'(s) && en_q[cur_ctx][s];
            assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];

            irq_gateway #(.EDGE(EDGE_MASK[s])) u_gw (
                .clk        (clk),
                .rst        (rst),
                .src_i      (irq_src_i[s]),
                .claim_i    (claim_vec[s]),
                .complete_i (done_vec[s]),
                .pending_o  (pend_vec[s])
            );
        end

        for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
            irq_ctx_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
                .clk      (clk),
                .rst      (rst),
                .pend_i   (pend_vec),
                .en_i     (en_q[c]),
                .prio_i   (prio_flat),
                .thr_i    (thr_q[c]),
                .win_id_o (win_id[c]),
                .irq_o    (ctx_irq_o[c])
            );
        end
    endgenerate

    // Read mux
    always_comb begin
        rd_mux = '0;
        case (sel.kind)
            RK_PRIO:   rd_mux[PRIO_W-1:0] = prio_q[cur_id];
            RK_ENABLE: begin
                for (int b = 0; b < 32; b++) begin
                    if (int'(sel.idx) * 32 + b < NUM_SRC)
                        rd_mux[b] = en_q[cur_ctx][int'(sel.idx) * 32 + b];
                end
            end
            RK_THRESH: rd_mux[PRIO_W-1:0] = thr_q[cur_ctx];
            RK_CLAIM:  rd_mux[ID_W-1:0]   = cur_win;
            default:   rd_mux = '0;
        endcase
    end

    // Register file
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
            for (int c = 0; c < NUM_CTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
            bus_rdata_o <= '0;
        end else begin
            if (bus_req_i && bus_we_i) begin
                case (sel.kind)
                    RK_PRIO: begin
                        if (cur_id != '0)
                            prio_q[cur_id] <= bus_wdata_i[PRIO_W-1:0];
                    end
                    RK_ENABLE: begin
                        for (int i = 1; i < NUM_SRC; i++) begin
                            if (i / 32 == int'(sel.idx))
                                en_q[cur_ctx][i] <= bus_wdata_i[i % 32];
                        end
                    end
                    RK_THRESH: thr_q[cur_ctx] <= bus_wdata_i[PRIO_W-1:0];
                    default: ;
                endcase
            end
            if (bus_req_i && !bus_we_i)
                bus_rdata_o <= rd_mux;
        end
    end

    AST_EMPTY_CLAIM: assert property (@(posedge clk) disable iff (rst)
        (claim_rd && cur_win == '0) |=> (bus_rdata_o == '0)); // R5

    AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (rst)
        $onehot0(claim_vec)); // R6

endmodule

// File: tb/sim_pic_core.sv
`timescale 1ns/1ps
module sim_pic_core;

    localparam int NSRC = 16;
    localparam int NCTX = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req = 1'b0;
    logic             we  = 1'b0;
    logic [25:0]      addr = '0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata;
    logic [NSRC-1:0]  src = '0;
    logic [NCTX-1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pic_core u0 (
        .clk(clk), .rst(rst), .bus_req_i(req), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_src_i(src), .ctx_irq_o(irq)
    );

    function automatic logic [25:0] a_prio(int id);  return 26'(4 * id); endfunction
    function automatic logic [25:0] a_en(int c, int w); return 26'(32'h2000 + c * 32'h80 + w * 4); endfunction
    function automatic logic [25:0] a_thr(int c);    return 26'(32'h200000 + c * 32'h1000); endfunction
    function automatic logic [25:0] a_clm(int c);    return 26'(32'h200000 + c * 32'h1000 + 4); endfunction

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [25:0] a, logic [31:0] d);
        @(negedge clk);
        req = 1; we = 1; addr = a; wdata = d;
        @(negedge clk);
        req = 0; we = 0;
    endtask

    task automatic rd(logic [25:0] a, output logic [31:0] d);
        @(negedge clk);
        req = 1; we = 0; addr = a;
        @(negedge clk);
        req = 0;
        d = rdata;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1; src = '0; req = 0;
        cycles(3);
        rst = 0;
        cycles(1);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        do_reset();
        chk("R1 irq", 32'(irq), 0);
        rd(a_prio(5), d);  chk("R1 prio", d, 0);
        rd(a_en(0, 0), d); chk("R1 enable", d, 0);
        rd(a_thr(1), d);   chk("R1 thr", d, 0);
        rd(a_clm(0), d);   chk("R1 claim", d, 0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        do_reset();
        wr(a_prio(3), 32'hFFFF_FFFF); rd(a_prio(3), d); chk("R2 prio width", d, 7);
        wr(a_prio(0), 32'h5);         rd(a_prio(0), d); chk("R2 id0", d, 0);
        wr(a_en(1, 0), 32'hFFFF_FFFF); rd(a_en(1, 0), d); chk("R3 enable bits", d, 32'h0000_FFFE);
        rd(a_en(0, 0), d); chk("R3 ctx independent", d, 0);
    endtask

    task automatic t_threshold;
        logic [31:0] d;
        do_reset();
        wr(a_prio(3), 2); wr(a_en(0, 0), 32'h8); wr(a_thr(0), 2);
        src[3] = 1; cycles(2);
        chk("R4 equal blocks", 32'(irq[0]), 0);
        wr(a_thr(0), 1); cycles(1);
        chk("R4 above raises", 32'(irq[0]), 1);
        wr(a_thr(0), 0); wr(a_prio(3), 0); cycles(1);
        chk("R4 prio0 masks", 32'(irq[0]), 0);
        wr(a_prio(3), 7); wr(a_thr(0), 7); cycles(1);
        chk("R4 thr7 blocks", 32'(irq[0]), 0);
        wr(a_thr(0), 32'hFFFF_FFFE); rd(a_thr(0), d);
        chk("R4 thr width", d, 6);
        chk("R4 prio7 over 6", 32'(irq[0]), 1);
    endtask

    task automatic t_claim;
        logic [31:0] d;
        do_reset();
        wr(a_prio(3), 3); wr(a_prio(6), 6); wr(a_en(0, 0), 32'h48);
        src[3] = 1; src[6] = 1; cycles(2);
        rd(a_clm(0), d); chk("R5 highest wins", d, 6);
        chk("R5 next still up", 32'(irq[0]), 1);
        rd(a_clm(0), d); chk("R5 second", d, 3);
        cycles(2);
        chk("R6 held in service", 32'(irq[0]), 0);
        rd(a_clm(0), d); chk("R5 empty", d, 0);
        wr(a_clm(1), 3); cycles(2);
        chk("R8 foreign complete ignored", 32'(irq[0]), 0);
        wr(a_clm(0), 3); cycles(2);
        chk("R9 level rearms", 32'(irq[0]), 1);
        rd(a_clm(0), d); chk("R9 reclaim", d, 3);
        src[3] = 0;
        wr(a_clm(0), 3); cycles(2);
        chk("R9 low input stays idle", 32'(irq[0]), 0);
        wr(a_clm(0), 6); cycles(2);
        rd(a_clm(0), d); chk("R9 src6 rearmed", d, 6);
    endtask

    task automatic t_tie;
        logic [31:0] d;
        do_reset();
        wr(a_prio(2), 4); wr(a_prio(4), 5); wr(a_prio(5), 5);
        wr(a_en(0, 0), 32'h34);
        src[2] = 1; src[4] = 1; src[5] = 1; cycles(2);
        rd(a_clm(0), d); chk("R7 tie low id", d, 4);
        rd(a_clm(0), d); chk("R7 tie next", d, 5);
        rd(a_clm(0), d); chk("R7 lower prio last", d, 2);
    endtask

    task automatic t_edge;
        logic [31:0] d;
        do_reset();
        wr(a_prio(9), 2); wr(a_en(0, 0), 32'h200);
        src[9] = 1; cycles(2);
        chk("R10 edge pends", 32'(irq[0]), 1);
        src[9] = 0; cycles(1);
        // claim and a new rising edge in the same cycle
        @(negedge clk);
        req = 1; we = 0; addr = a_clm(0); src[9] = 1;
        @(negedge clk);
        req = 0; d = rdata;
        chk("R10 claim with edge", d, 9);
        cycles(2);
        chk("R6 edge held off", 32'(irq[0]), 0);
        wr(a_clm(0), 9); cycles(2);
        chk("R10 remembered edge", 32'(irq[0]), 1);
        rd(a_clm(0), d); chk("R10 reclaim", d, 9);
        wr(a_clm(0), 9); cycles(3);
        chk("R10 high level no retrigger", 32'(irq[0]), 0);
    endtask

    task automatic t_ctx;
        logic [31:0] d;
        do_reset();
        wr(a_prio(7), 1); wr(a_en(1, 0), 32'h80);
        src[7] = 1; cycles(2);
        chk("R11 ctx1 raised", 32'(irq[1]), 1);
        chk("R11 ctx0 quiet", 32'(irq[0]), 0);
        rd(a_clm(0), d); chk("R11 ctx0 claim empty", d, 0);
        rd(a_clm(1), d); chk("R11 ctx1 claim", d, 7);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_threshold();
        t_claim();
        t_tie();
        t_edge();
        t_ctx();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule